// File: doc/BRIEF.md
# Secondary Cache Tag Diagnostic Path

This block holds the tag side of a secondary cache on a 486-style processor bus. It also gives software a diagnostic mode in which every tag entry can be written and read back through an aligned memory window. In this mode the stored tags are not moved on the CPU data bus. Two 8-bit staging registers in an indexed configuration space hold a 16-bit entry. A CPU write inside the window copies the staging pair into the tag line that the address selects. A CPU read inside the window copies that line's entry back into the staging pair.

With diagnostic mode off, the block acts as an ordinary tag lookup. It marks a read hit, a write hit, a read miss that needs a line fill, and a fill that must first write back a dirty victim. With the mode on, the window decode takes the place of the tag comparator. Data SRAMs, line fills, victim write-backs and DRAM writes are held off for window cycles. Cycles outside the window go to main memory uncached and end on the memory side's ready.

A tag entry is 16 bits. Bit 15 is valid, bit 14 is dirty, and the low TAG_W bits hold the address bits above the tag index. Configuration indexes are: 20 control (bit 0 adds a second write wait state, bit 1 turns diagnostic mode on, bit 2 selects write-through), 21 size code (bits 1:0), 22 window base, 23 staging low byte, 24 staging high byte.

Top module: `tagtest_ctrl`

## Requirements
- R1: After reset, every configuration index reads 0 and t2, rdy and brdy are low.
- R2: Size code c (0 to 3) gives a window of 2^(MIN_LOG2+c) bytes. Base register bit i stands for address bit MIN_LOG2+i, and base bits below c are ignored. An access is a window access only if all the remaining bits match.
- R3: A window write holds t2 until it ends. It asserts rdy in its second T2 cycle when control bit 0 is 0, and in its third T2 cycle when control bit 0 is 1.
- R4: A window write stores {index 24, index 23} into the tag entry of the addressed line.
- R5: A window read asserts rdy in its first T2 cycle. At the end of that cycle it loads the entry into index 23 (bits 7:0) and index 24 (bits 15:8).
- R6: Every byte of a 16-byte line selects the same tag entry, and lines 0x10 apart select different entries. The entry index is address bits 4 and up, so one index is reachable from any window base.
- R7: A window cycle never asserts brdy.
- R8: In diagnostic mode, a window cycle asserts hit and keeps dsram_en, fill_req and castout_req low.
- R9: A window write never asserts dram_wr, even with write-through set. A write outside the window asserts dram_wr.
- R10: In diagnostic mode, a cycle outside the window gets neither rdy nor brdy from the block and ends on ext_rdy. It does not assert hit or fill_req.
- R11: With diagnostic mode off, a read whose entry is valid with a matching tag gets brdy, hit and dsram_en in its first T2 cycle. Any other read is a miss: it asserts fill_req, asserts castout_req if the entry is dirty, and ends on ext_rdy.
- R12: With diagnostic mode off, a write hit asserts rdy after the same wait states as R3, with hit and dsram_en, and asserts dram_wr only when write-through is set. A write miss asserts dram_wr and ends on ext_rdy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_ads | input | 1 | Cycle start strobe (T1) |
| cpu_adr | input | ADDR_W-2 | Dword address, bits ADDR_W-1:2 |
| cpu_be | input | 4 | Byte enables |
| cpu_wr | input | 1 | 1 = write cycle |
| ext_rdy | input | 1 | Ready from main memory or expansion bus |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 5 | Configuration index |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_idx |
| t2 | output | 1 | Cycle in progress (T2 state) |
| rdy | output | 1 | Non-burst ready from this block |
| brdy | output | 1 | Burst ready for cache read hits |
| hit | output | 1 | Hit indication during T2 |
| dsram_en | output | 1 | Data SRAM enable |
| fill_req | output | 1 | Line fill request |
| castout_req | output | 1 | Dirty victim write-back request |
| dram_wr | output | 1 | Forward write to DRAM |

## Verification
The bench targets the wait-state count of window writes under both timing settings. A sequencer that counts from the wrong T2 would end one cycle early or late. It reads each line back at a different byte offset, and at a second window base that aliases to the same index. Wrong low-bit or index slicing would then return a neighbouring entry or the stale staging value. It sets write-through together with diagnostic mode, which catches a design that leaks window writes to DRAM. It moves the window base with masked low bits set, which catches a decoder that compares bits it should ignore. In normal mode it checks lookups against entries that are invalid, dirty or mismatched, to catch fills, write-backs or bursts raised in the wrong case.

// File: rtl/tagtest_pkg.sv
package tagtest_pkg;
   localparam int CFG_IDX_W = 5;
   localparam logic [CFG_IDX_W-1:0] IX_CTL  = 5'd20;
   localparam logic [CFG_IDX_W-1:0] IX_SIZE = 5'd21;
   localparam logic [CFG_IDX_W-1:0] IX_BASE = 5'd22;
   localparam logic [CFG_IDX_W-1:0] IX_TLO  = 5'd23;
   localparam logic [CFG_IDX_W-1:0] IX_THI  = 5'd24;

   localparam int ENTRY_W   = 16;
   localparam int VALID_BIT = 15;
   localparam int DIRTY_BIT = 14;
   localparam int SIZE_MAX  = 3;

   typedef enum logic [2:0] {
      CYC_EXT, CYC_TRD, CYC_TWR, CYC_NRH, CYC_NWH
   } cyc_kind_e;
endpackage

// File: rtl/tt_cfg_regs.sv
module tt_cfg_regs
   import tagtest_pkg::*;
#(
   parameter int BASE_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [CFG_IDX_W-1:0] cfg_idx,
   input  logic [7:0]           cfg_wdata,
   output logic [7:0]           cfg_rdata,
   input  logic                 cap_en,
   input  logic [ENTRY_W-1:0]   cap_entry,
   output logic                 slow_wr,
   output logic                 test_en,
   output logic                 wthru,
   output logic [1:0]           size_code,
   output logic [BASE_W-1:0]    win_base,
   output logic [ENTRY_W-1:0]   stage_entry
);
   logic [2:0] ctl_q;
   logic [7:0] lo_q, hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q     <= '0;
         size_code <= '0;
         win_base  <= '0;
         lo_q      <= '0;
         hi_q      <= '0;
      end else begin
         if (cfg_we) begin
            case (cfg_idx)
               IX_CTL:  ctl_q     <= cfg_wdata[2:0];
               IX_SIZE: size_code <= cfg_wdata[1:0];
               IX_BASE: win_base  <= cfg_wdata[BASE_W-1:0];
               IX_TLO:  lo_q      <= cfg_wdata;
               IX_THI:  hi_q      <= cfg_wdata;
               default: ;
            endcase
         end
         if (cap_en) begin
            lo_q <= cap_entry[7:0];
            hi_q <= cap_entry[15:8];
         end
      end
   end

   assign slow_wr     = ctl_q[0];
   assign test_en     = ctl_q[1];
   assign wthru       = ctl_q[2];
   assign stage_entry = {hi_q, lo_q};

   always_comb begin
      case (cfg_idx)
         IX_CTL:  cfg_rdata = {5'b0, ctl_q};
         IX_SIZE: cfg_rdata = {6'b0, size_code};
         IX_BASE: cfg_rdata = 8'(win_base);
         IX_TLO:  cfg_rdata = lo_q;
         IX_THI:  cfg_rdata = hi_q;
         default: cfg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/tt_win_decode.sv
module tt_win_decode #(
   parameter int BASE_W = 8
) (
   input  logic [BASE_W-1:0] adr_hi,
   input  logic [BASE_W-1:0] win_base,
   input  logic [1:0]        size_code,
   output logic              in_win
);
   logic [BASE_W-1:0] bit_ok;

   for (genvar i = 0; i < BASE_W; i++) begin : g_bit
      if (i < 3) begin : g_maskable
         assign bit_ok[i] = (int'(size_code) > i) || (adr_hi[i] == win_base[i]);
      end else begin : g_fixed
         assign bit_ok[i] = (adr_hi[i] == win_base[i]);
      end
   end

   assign in_win = &bit_ok;
endmodule

// File: rtl/tt_tag_ram.sv
module tt_tag_ram #(
   parameter int IDX_W = 10,
   parameter int W     = 16,
   localparam int DEPTH = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             we,
   input  logic [IDX_W-1:0] waddr,
   input  logic [W-1:0]     wdata,
   input  logic [IDX_W-1:0] raddr_a,
   output logic [W-1:0]     rdata_a,
   input  logic [IDX_W-1:0] raddr_b,
   output logic [W-1:0]     rdata_b
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata_a = mem[raddr_a];
   assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/tt_cycle_fsm.sv
module tt_cycle_fsm
   import tagtest_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_ads,
   input  logic cpu_wr,
   input  logic ext_rdy,
   input  logic test_en,
   input  logic slow_wr,
   input  logic wthru,
   input  logic in_win,
   input  logic nhit,
   input  logic victim_dirty,
   output logic start,
   output logic t2,
   output logic rdy,
   output logic brdy,
   output logic hit,
   output logic dsram_en,
   output logic fill_req,
   output logic castout_req,
   output logic dram_wr,
   output logic tag_we,
   output logic cap_en
);
   cyc_kind_e  kind_q, kind_d;
   logic       busy_q, wr_q, fill_q, co_q, dwr_q;
   logic [1:0] cnt_q, ws_q;
   logic       wr_done, finish;

   assign start = cpu_ads && !busy_q;

   always_comb begin
      if (test_en) kind_d = in_win ? (cpu_wr ? CYC_TWR : CYC_TRD) : CYC_EXT;
      else         kind_d = nhit   ? (cpu_wr ? CYC_NWH : CYC_NRH) : CYC_EXT;
   end

   assign wr_done = busy_q && (kind_q == CYC_TWR || kind_q == CYC_NWH) && cnt_q == ws_q;
   assign rdy     = (busy_q && kind_q == CYC_TRD) || wr_done;
   assign brdy    = busy_q && kind_q == CYC_NRH;
   assign finish  = rdy || brdy || (busy_q && kind_q == CYC_EXT && ext_rdy);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         kind_q <= CYC_EXT;
         wr_q   <= 1'b0;
         cnt_q  <= '0;
         ws_q   <= 2'd1;
         fill_q <= 1'b0;
         co_q   <= 1'b0;
         dwr_q  <= 1'b0;
      end else if (start) begin
         busy_q <= 1'b1;
         kind_q <= kind_d;
         wr_q   <= cpu_wr;
         cnt_q  <= '0;
         ws_q   <= slow_wr ? 2'd2 : 2'd1;
         fill_q <= !test_en && !nhit && !cpu_wr;
         co_q   <= !test_en && !nhit && !cpu_wr && victim_dirty;
         dwr_q  <= cpu_wr && (kind_d == CYC_EXT || (kind_d == CYC_NWH && wthru));
      end else if (finish) begin
         busy_q <= 1'b0;
      end else if (busy_q) begin
         cnt_q <= cnt_q + 2'd1;
      end
   end

   assign t2          = busy_q;
   assign hit         = busy_q && kind_q != CYC_EXT;
   assign dsram_en    = busy_q && (kind_q == CYC_NRH || kind_q == CYC_NWH);
   assign fill_req    = busy_q && fill_q;
   assign castout_req = busy_q && co_q;
   assign dram_wr     = busy_q && wr_q && dwr_q;
   assign tag_we      = wr_done && kind_q == CYC_TWR;
   assign cap_en      = busy_q && kind_q == CYC_TRD;
endmodule

// File: rtl/tagtest_ctrl.sv
module tagtest_ctrl
   import tagtest_pkg::*;
#(
   parameter int IDX_W  = 10,
   parameter int BASE_W = 8,
   localparam int MIN_LOG2 = 4 + IDX_W - SIZE_MAX,
   localparam int ADDR_W   = MIN_LOG2 + BASE_W,
   localparam int TAG_W    = ADDR_W - 4 - IDX_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cpu_ads,
   input  logic [ADDR_W-1:2]    cpu_adr,
   input  logic [3:0]           cpu_be,
   input  logic                 cpu_wr,
   input  logic                 ext_rdy,
   input  logic                 cfg_we,
   input  logic [CFG_IDX_W-1:0] cfg_idx,
   input  logic [7:0]           cfg_wdata,
   output logic [7:0]           cfg_rdata,
   output logic                 t2,
   output logic                 rdy,
   output logic                 brdy,
   output logic                 hit,
   output logic                 dsram_en,
   output logic                 fill_req,
   output logic                 castout_req,
   output logic                 dram_wr
);
   if (IDX_W < SIZE_MAX + 1 || IDX_W > 16) begin : g_bad_idx
      $error("tagtest_ctrl: IDX_W out of range");
   end
   if (BASE_W < SIZE_MAX + 1 || TAG_W > DIRTY_BIT - 1) begin : g_bad_base
      $error("tagtest_ctrl: BASE_W out of range");
   end

   logic                slow_wr, test_en, wthru, in_win, nhit;
   logic                start, tag_we, cap_en;
   logic [1:0]          size_code;
   logic [BASE_W-1:0]   win_base;
   logic [ENTRY_W-1:0]  stage_entry, entry_a, entry_b;
   logic [IDX_W-1:0]    idx_now, idx_q;
   logic                unused_bits;

   assign idx_now     = cpu_adr[4+IDX_W-1:4];
   assign unused_bits = ^{cpu_adr[3:2], cpu_be, entry_a[DIRTY_BIT-1:TAG_W]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     idx_q <= '0;
      else if (start) idx_q <= idx_now;
   end

   tt_cfg_regs #(.BASE_W(BASE_W)) u_cfg (
      .clk, .rst_n, .cfg_we, .cfg_idx, .cfg_wdata, .cfg_rdata,
      .cap_en, .cap_entry(entry_b),
      .slow_wr, .test_en, .wthru, .size_code, .win_base, .stage_entry
   );

   tt_win_decode #(.BASE_W(BASE_W)) u_win (
      .adr_hi(cpu_adr[ADDR_W-1:MIN_LOG2]), .win_base, .size_code, .in_win
   );

   tt_tag_ram #(.IDX_W(IDX_W), .W(ENTRY_W)) u_ram (
      .clk, .we(tag_we), .waddr(idx_q), .wdata(stage_entry),
      .raddr_a(idx_now), .rdata_a(entry_a),
      .raddr_b(idx_q), .rdata_b(entry_b)
   );

   assign nhit = entry_a[VALID_BIT] && (entry_a[TAG_W-1:0] == cpu_adr[ADDR_W-1:ADDR_W-TAG_W]);

   tt_cycle_fsm u_fsm (
      .clk, .rst_n, .cpu_ads, .cpu_wr, .ext_rdy,
      .test_en, .slow_wr, .wthru, .in_win, .nhit,
      .victim_dirty(entry_a[DIRTY_BIT]),
      .start, .t2, .rdy, .brdy, .hit, .dsram_en,
      .fill_req, .castout_req, .dram_wr, .tag_we, .cap_en
   );
endmodule

// File: rtl/tagtest_ctrl_chk.sv
module tagtest_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic cpu_wr,
   input logic t2,
   input logic rdy,
   input logic brdy,
   input logic hit,
   input logic dsram_en,
   input logic fill_req,
   input logic castout_req,
   input logic dram_wr
);
   // R7
   window_no_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !dsram_en) |-> !brdy);

   // R8
   window_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !dsram_en) |-> !(fill_req || castout_req));

   // R9
   window_no_dram_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !dsram_en) |-> !dram_wr);

   // R3
   write_not_zero_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(t2) && hit && cpu_wr) |-> !rdy);

   // R5
   ready_ends_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy || brdy) |=> !t2);

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !t2 |-> !(rdy || brdy || hit || fill_req || dram_wr));

   // R11
   ready_kinds_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rdy && brdy));
endmodule

bind tagtest_ctrl tagtest_ctrl_chk i_chk (.*);

// File: tb/test_tagtest_ctrl.sv
module test_tagtest_ctrl;
   localparam int ADDR_W = 19;

   typedef struct {
      int       len;
      bit       rdy;
      bit       brdy;
      bit [4:0] fl;
      string    req;
   } exp_t;

   logic clk = 0, rst_n = 0;
   logic cpu_ads = 0, cpu_wr = 0, ext_rdy = 0, cfg_we = 0;
   logic [ADDR_W-1:2] cpu_adr = '0;
   logic [3:0] cpu_be = '0;
   logic [4:0] cfg_idx = '0;
   logic [7:0] cfg_wdata = '0, cfg_rdata;
   logic t2, rdy, brdy, hit, dsram_en, fill_req, castout_req, dram_wr;

   int checks = 0, failures = 0;
   exp_t exp_q[$];

   always #5 clk = ~clk;

   tagtest_ctrl i_tagtest_ctrl (
      .clk, .rst_n, .cpu_ads, .cpu_adr, .cpu_be, .cpu_wr, .ext_rdy,
      .cfg_we, .cfg_idx, .cfg_wdata, .cfg_rdata,
      .t2, .rdy, .brdy, .hit, .dsram_en, .fill_req, .castout_req, .dram_wr
   );

   task automatic chk(string req, int got, int want);
      checks++;
      if (got != want) begin
         failures++;
         $display("FAIL %s got=%0h exp=%0h", req, got, want);
      end
   endtask

   task automatic cfg_wr(logic [4:0] idx, logic [7:0] d);
      @(negedge clk); cfg_we = 1; cfg_idx = idx; cfg_wdata = d;
      @(negedge clk); cfg_we = 0;
   endtask

   task automatic cfg_chk(logic [4:0] idx, logic [7:0] want, string req);
      cfg_idx = idx; #1;
      chk(req, cfg_rdata, want);
   endtask

   // flags: {hit, dsram_en, fill_req, castout_req, dram_wr}
   task automatic bus(int a, bit wr, int ext_len, int len, bit r, bit b, bit [4:0] fl, string req);
      exp_t e;
      e.len = len; e.rdy = r; e.brdy = b; e.fl = fl; e.req = req;
      exp_q.push_back(e);
      @(negedge clk);
      cpu_ads = 1; cpu_adr = a[ADDR_W-1:2]; cpu_be = 4'b1 << a[1:0]; cpu_wr = wr;
      @(negedge clk);
      cpu_ads = 0;
      for (int n = 1; n < 10; n++) begin
         ext_rdy = (ext_len == n);
         #2;
         if (rdy || brdy || ext_rdy) begin
            @(negedge clk); ext_rdy = 0;
            break;
         end
         @(negedge clk);
      end
   endtask

   // monitor
   int m_len = 0;
   bit m_rdy = 0, m_brdy = 0;
   bit [4:0] m_fl = '0;
   always begin
      @(negedge clk); #1;
      if (t2) begin
         m_len++;
         m_rdy  |= rdy;
         m_brdy |= brdy;
         m_fl   |= {hit, dsram_en, fill_req, castout_req, dram_wr};
         if (rdy || brdy || ext_rdy) begin
            if (exp_q.size() == 0) begin
               chk("R10 unexpected cycle end", 1, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk({e.req, " length"}, m_len, e.len);
               chk({e.req, " rdy"}, m_rdy, e.rdy);
               chk({e.req, " brdy"}, m_brdy, e.brdy);
               chk({e.req, " flags"}, m_fl, e.fl);
            end
            m_len = 0; m_rdy = 0; m_brdy = 0; m_fl = '0;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog got=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      for (int i = 20; i <= 24; i++) cfg_chk(5'(i), 8'h00, "R1");
      chk("R1 t2", t2, 0); chk("R1 rdy", rdy, 0); chk("R1 brdy", brdy, 0);
      rst_n = 1;
      cfg_wr(21, 8'h03); cfg_wr(22, 8'h10); cfg_wr(20, 8'h02);

      // R3/R4 fast window write, then R5 read back at another byte offset
      cfg_wr(23, 8'h03); cfg_wr(24, 8'h80);
      bus('h8020, 1, 0, 2, 1, 0, 5'b10000, "R3 fast write");
      cfg_wr(23, 8'hAA); cfg_wr(24, 8'h55);
      bus('h8027, 0, 0, 1, 1, 0, 5'b10000, "R5 R7 read");
      cfg_chk(23, 8'h03, "R4 R5 low"); cfg_chk(24, 8'h80, "R4 R5 high");

      // R3 slow write, R6 distinct lines
      cfg_wr(20, 8'h03);
      cfg_wr(23, 8'h05); cfg_wr(24, 8'hC0);
      bus('h8030, 1, 0, 3, 1, 0, 5'b10000, "R3 slow write");
      cfg_wr(23, 8'h03); cfg_wr(24, 8'h00);
      bus('h8040, 1, 0, 3, 1, 0, 5'b10000, "R3 slow write");
      bus('h803C, 0, 0, 1, 1, 0, 5'b10000, "R8 dirty entry read");
      cfg_chk(23, 8'h05, "R6 line 3 low"); cfg_chk(24, 8'hC0, "R6 line 3 high");
      bus('h802E, 0, 0, 1, 1, 0, 5'b10000, "R6 read");
      cfg_chk(23, 8'h03, "R6 line 2 low"); cfg_chk(24, 8'h80, "R6 line 2 high");

      // R9/R10 write-through on in test mode
      cfg_wr(20, 8'h07);
      bus('h8050, 1, 0, 3, 1, 0, 5'b10000, "R9 window write");
      bus('h0100, 1, 2, 2, 0, 0, 5'b00001, "R9 R10 outside write");
      bus('h0200, 0, 1, 1, 0, 0, 5'b00000, "R10 outside read");

      // R2 window sizes and masked base bits
      cfg_wr(20, 8'h02); cfg_wr(21, 8'h00);
      bus('h8800, 0, 1, 1, 0, 0, 5'b00000, "R2 small window outside");
      bus('h87F0, 0, 0, 1, 1, 0, 5'b10000, "R2 small window inside");
      cfg_wr(21, 8'h03); cfg_wr(22, 8'h13);
      bus('h9000, 0, 0, 1, 1, 0, 5'b10000, "R2 masked base bits");
      bus('hC000, 0, 1, 1, 0, 0, 5'b00000, "R2 above window");

      // R6 alias through another window base
      cfg_wr(22, 8'h18);
      cfg_wr(23, 8'hEE); cfg_wr(24, 8'hEE);
      bus('hC024, 0, 0, 1, 1, 0, 5'b10000, "R6 alias read");
      cfg_chk(23, 8'h03, "R6 alias low"); cfg_chk(24, 8'h80, "R6 alias high");

      // R11/R12 normal mode
      cfg_wr(20, 8'h00);
      bus('hC020, 0, 0, 1, 0, 1, 5'b11000, "R11 read hit");
      bus('h4030, 0, 2, 2, 0, 0, 5'b00110, "R11 dirty miss");
      bus('hC040, 0, 1, 1, 0, 0, 5'b00100, "R11 invalid entry");
      bus('hC028, 1, 0, 2, 1, 0, 5'b11000, "R12 write hit");
      cfg_wr(20, 8'h04);
      bus('hC028, 1, 0, 2, 1, 0, 5'b11001, "R12 write-through hit");
      bus('h4030, 1, 1, 1, 0, 0, 5'b00001, "R12 write miss");

      repeat (4) @(negedge clk);
      chk("R10 pending cycles", exp_q.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule